// File: doc/BRIEF.md
# Completion Interrupt Coalescer

This block sits beside a descriptor-ring copy engine and turns its stream of per-descriptor completion pulses into one level interrupt for software. Instead of interrupting on every finished descriptor, it holds completions back until either enough of them have piled up or the oldest one has waited long enough. Both limits are 7-bit values packed into a single moderation register together with a global enable. With moderation switched off, every completion raises the interrupt at once.

The interrupt source is a single done flag in a status register that software clears by writing a one to it. A separate enable mask register gates the flag onto the interrupt line, so a service routine can mask the line, drain the ring, clear the flag and unmask again. Time is measured from a free-running microsecond tick, prescaled into coarse units (20 ticks per unit by default). Two states drive the moderation: CO_IDLE (nothing pending, age timer held at zero) and CO_GATHER (at least one completion pending, age timer running). A completion that does not itself raise an event moves CO_IDLE to CO_GATHER; any event (count limit, age limit, or a completion with moderation off) returns to CO_IDLE and clears the pending count, the age and the prescaler.

Top module: `cpl_irq_coalescer`

## Requirements
- R1: After reset the moderation register (offset 0x20C) reads 0x0000_9414 (enabled, count limit 20, age limit 20), the status register (0x220) and the mask register (0x228) read 0, and irq is low.
- R2: With moderation enabled (0x20C bit 15 = 1), the done flag (0x220 bit 16) is set on the clock edge at which the pending completion count, including the completion arriving in that cycle, becomes greater than the count limit in 0x20C bits [14:8]; a count limit of 0 fires on the first completion.
- R3: With moderation enabled, the done flag is set one cycle after the age of the oldest pending completion exceeds the age limit in 0x20C bits [6:0]; age is counted in units of TICKS_PER_UNIT microsecond ticks starting at the edge that registered the first pending completion, so with a tick every cycle the flag rises (limit+1)*TICKS_PER_UNIT+1 cycles after that edge, regardless of later completions.
- R4: Every event clears the pending count and the age; completions that arrive while the done flag is already set are still counted toward the next event.
- R5: With moderation disabled (0x20C bit 15 = 0), each completion sets the done flag on the clock edge that registers it.
- R6: Writing 0x220 with bit 16 = 1 clears the done flag; writing bit 16 = 0 leaves it unchanged; if an event occurs in the same cycle as the clearing write, the flag stays set.
- R7: The mask register 0x228 bit 16 is read/write, and irq equals the done flag ANDed with that mask bit, changing on the edge after either register is written.
- R8: Register 0x20C reads back bit 15 and fields [14:8] and [6:0] as written, with bit 7 and bits [31:16] reading 0; any address other than 0x20C, 0x220 and 0x228 reads 0.
- R9: While nothing is pending the age timer does not advance, so an idle block raises no event however long the tick runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpl_pulse | input | 1 | One completion per cycle in which it is high |
| us_tick | input | 1 | Free-running microsecond tick, one-cycle pulses |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with TICKS_PER_UNIT set to 4 and holds the tick high every cycle, so one age unit lasts four clocks. That makes age limits of 0 and 2 fire within a few dozen cycles, letting the exact rise cycle of an age-triggered event be predicted and compared, and lets an idle stretch span many age units cheaply. Count limits of 0 and 3 cover the first-completion boundary and a multi-completion burst that straddles a status clear.

// File: rtl/cpl_coal_pkg.sv
package cpl_coal_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int THR_W  = 7;

    localparam logic [ADDR_W-1:0] OFF_MOD  = 12'h20C;
    localparam logic [ADDR_W-1:0] OFF_STAT = 12'h220;
    localparam logic [ADDR_W-1:0] OFF_MASK = 12'h228;

    localparam int MOD_EN_BIT  = 15;
    localparam int CNT_LSB     = 8;
    localparam int TIME_LSB    = 0;
    localparam int DONE_BIT    = 16;

    localparam logic [THR_W-1:0] DEF_CNT_LIMIT  = 7'd20;
    localparam logic [THR_W-1:0] DEF_TIME_LIMIT = 7'd20;

    typedef enum logic [0:0] {
        CO_IDLE   = 1'b0,
        CO_GATHER = 1'b1
    } co_state_e;

endpackage

// File: rtl/cpl_coal_regs.sv
module cpl_coal_regs
    import cpl_coal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              fire,
    output logic              mod_en,
    output logic [THR_W-1:0]  cnt_limit,
    output logic [THR_W-1:0]  time_limit,
    output logic              done_flag,
    output logic              done_mask,
    output logic [DATA_W-1:0] rdata
);

    logic wr_mod, wr_stat, wr_mask;
    logic unused_wbits;

    assign wr_mod  = we && (addr == OFF_MOD);
    assign wr_stat = we && (addr == OFF_STAT);
    assign wr_mask = we && (addr == OFF_MASK);
    assign unused_wbits = ^{wdata[DATA_W-1:DONE_BIT+1], wdata[7]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_en     <= 1'b1;
            cnt_limit  <= DEF_CNT_LIMIT;
            time_limit <= DEF_TIME_LIMIT;
            done_mask  <= 1'b0;
            done_flag  <= 1'b0;
        end else begin
            if (wr_mod) begin
                mod_en     <= wdata[MOD_EN_BIT];
                cnt_limit  <= wdata[CNT_LSB +: THR_W];
                time_limit <= wdata[TIME_LSB +: THR_W];
            end
            if (wr_mask) begin
                done_mask <= wdata[DONE_BIT];
            end
            // a new event wins over a clearing write in the same cycle
            done_flag <= fire || (done_flag && !(wr_stat && wdata[DONE_BIT]));
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == OFF_MOD) begin
            rdata[MOD_EN_BIT]          = mod_en;
            rdata[CNT_LSB +: THR_W]    = cnt_limit;
            rdata[TIME_LSB +: THR_W]   = time_limit;
        end else if (addr == OFF_STAT) begin
            rdata[DONE_BIT] = done_flag;
        end else if (addr == OFF_MASK) begin
            rdata[DONE_BIT] = done_mask;
        end
    end

endmodule

// File: rtl/cpl_coal_fsm.sv
module cpl_coal_fsm
    import cpl_coal_pkg::*;
#(
    parameter int TICKS_PER_UNIT = 20
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpl_in,
    input  logic             us_tick,
    input  logic             mod_en,
    input  logic [THR_W-1:0] cnt_limit,
    input  logic [THR_W-1:0] time_limit,
    output logic             fire,
    output logic [THR_W:0]   pend_cnt,
    output logic [THR_W:0]   age_units,
    output logic             idle
);

    localparam int PRE_W = (TICKS_PER_UNIT > 1) ? $clog2(TICKS_PER_UNIT) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_UNIT - 1);

    co_state_e state, state_nxt;
    logic [PRE_W-1:0] presc;
    logic [THR_W:0]   pend_sum;
    logic             cnt_hit, time_hit, unit_end;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CO_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // next-state decode
    always_comb begin
        state_nxt = state;
        unique case (state)
            CO_IDLE:   state_nxt = (cpl_in && !fire) ? CO_GATHER : CO_IDLE;
            CO_GATHER: state_nxt = fire ? CO_IDLE : CO_GATHER;
            default:   state_nxt = CO_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        pend_sum = (&pend_cnt) ? pend_cnt : pend_cnt + {{THR_W{1'b0}}, cpl_in};
        cnt_hit  = pend_sum > {1'b0, cnt_limit};
        time_hit = (state == CO_GATHER) && (age_units > {1'b0, time_limit});
        fire     = mod_en ? (cnt_hit || time_hit) : cpl_in;
        unit_end = us_tick && (presc == PRE_LAST);
        idle     = (state == CO_IDLE);
    end

    // pending counter, prescaler and age timer
    always_ff @(posedge clk) begin
        if (!rst_n || fire) begin
            pend_cnt  <= '0;
            age_units <= '0;
            presc     <= '0;
        end else begin
            pend_cnt <= pend_sum;
            if (state == CO_IDLE) begin
                presc     <= '0;
                age_units <= '0;
            end else if (us_tick) begin
                if (unit_end) begin
                    presc <= '0;
                    if (!(&age_units)) begin
                        age_units <= age_units + 1'b1;
                    end
                end else begin
                    presc <= presc + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/cpl_irq_coalescer.sv
module cpl_irq_coalescer
    import cpl_coal_pkg::*;
#(
    parameter int TICKS_PER_UNIT = 20
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpl_pulse,
    input  logic        us_tick,
    input  logic        reg_we,
    input  logic [11:0] reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq
);

    logic             mod_en;
    logic [THR_W-1:0] cnt_limit, time_limit;
    logic             done_flag, done_mask, fire, idle;
    logic [THR_W:0]   pend_cnt, age_units;

    cpl_coal_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (reg_we),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .fire       (fire),
        .mod_en     (mod_en),
        .cnt_limit  (cnt_limit),
        .time_limit (time_limit),
        .done_flag  (done_flag),
        .done_mask  (done_mask),
        .rdata      (reg_rdata)
    );

    cpl_coal_fsm #(
        .TICKS_PER_UNIT (TICKS_PER_UNIT)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpl_in     (cpl_pulse),
        .us_tick    (us_tick),
        .mod_en     (mod_en),
        .cnt_limit  (cnt_limit),
        .time_limit (time_limit),
        .fire       (fire),
        .pend_cnt   (pend_cnt),
        .age_units  (age_units),
        .idle       (idle)
    );

    assign irq = done_flag && done_mask;

endmodule

// File: rtl/cpl_coal_checker.sv
module cpl_coal_checker
    import cpl_coal_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cpl_pulse,
    input logic             reg_we,
    input logic [11:0]      reg_addr,
    input logic [31:0]      reg_wdata,
    input logic             irq,
    input logic             mod_en,
    input logic [THR_W-1:0] cnt_limit,
    input logic [THR_W-1:0] time_limit,
    input logic             done_flag,
    input logic             done_mask,
    input logic             fire,
    input logic [THR_W:0]   pend_cnt,
    input logic [THR_W:0]   age_units,
    input logic             idle
);

    a_r2_count_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_en && pend_cnt > {1'b0, cnt_limit}) |=> done_flag);

    a_r3_age_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_en && !idle && age_units > {1'b0, time_limit}) |=> done_flag);

    a_r4_event_clears: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (pend_cnt == '0 && age_units == '0 && idle));

    a_r5_direct_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (!mod_en && cpl_pulse) |=> done_flag);

    a_r6_clear_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFF_STAT && reg_wdata[DONE_BIT] && !fire) |=> !done_flag);

    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> done_flag);

    a_r7_gated_line: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (done_flag && done_mask));

    a_r9_idle_no_age: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (age_units == '0));

endmodule

bind cpl_irq_coalescer cpl_coal_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpl_pulse  (cpl_pulse),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .irq        (irq),
    .mod_en     (mod_en),
    .cnt_limit  (cnt_limit),
    .time_limit (time_limit),
    .done_flag  (done_flag),
    .done_mask  (done_mask),
    .fire       (fire),
    .pend_cnt   (pend_cnt),
    .age_units  (age_units),
    .idle       (idle)
);

// File: tb/cpl_irq_coalescer_test.sv
`timescale 1ns/1ps
module cpl_irq_coalescer_test;

    localparam int UNIT = 4;
    localparam int WATCHDOG = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpl_pulse = 1'b0;
    logic        us_tick = 1'b1;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 0;
    bit irq_prev = 0;
    int exp_q[$];

    always #4 clk = ~clk;

    cpl_irq_coalescer #(.TICKS_PER_UNIT(UNIT)) uut (
        .clk(clk), .rst_n(rst_n), .cpl_pulse(cpl_pulse), .us_tick(us_tick),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // monitor: every rise of irq must match the oldest expected rise cycle
    always @(negedge clk) begin
        if (rst_n && irq && !irq_prev) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2/R3/R5 unexpected irq rise", cyc, -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                check(cyc == e, "R2/R3/R5/R7 irq rise cycle", cyc, e);
            end
        end
        irq_prev <= irq;
    end

    // register write; optionally expect irq to rise on the write edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d, input bit rise);
        @(negedge clk);
        if (rise) exp_q.push_back(cyc + 1);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    // n back-to-back completions; rise_off > 0 pushes an expected rise
    task automatic burst(input int n, input int rise_off);
        @(negedge clk);
        if (rise_off > 0) exp_q.push_back(cyc + rise_off);
        cpl_pulse = 1'b1;
        repeat (n) @(negedge clk);
        cpl_pulse = 1'b0;
    endtask

    task automatic clear_done();
        wr(12'h220, 32'h0001_0000, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(12'h20C, 32'h0000_9414, "R1 moderation reset");
        rd(12'h220, 32'h0, "R1 status reset");
        rd(12'h228, 32'h0, "R1 mask reset");
        check(irq == 1'b0, "R1 irq reset", irq, 0);

        // R9 idle for many units with a running tick
        repeat (60) @(negedge clk);
        rd(12'h220, 32'h0, "R9 idle raises nothing");

        // R7 mask read/write
        wr(12'h228, 32'h0001_0000, 1'b0);
        rd(12'h228, 32'h0001_0000, "R7 mask readback");

        // R5 moderation off: each completion sets the flag at once
        wr(12'h20C, 32'h0, 1'b0);
        burst(1, 1);
        rd(12'h220, 32'h0001_0000, "R5 flag set by single completion");

        // R6 writing zero has no effect
        wr(12'h220, 32'h0, 1'b0);
        rd(12'h220, 32'h0001_0000, "R6 zero write keeps flag");

        // R7 masking drops irq, flag stays; unmasking raises it
        wr(12'h228, 32'h0, 1'b0);
        check(irq == 1'b0, "R7 masked irq low", irq, 0);
        rd(12'h220, 32'h0001_0000, "R7 flag kept while masked");
        wr(12'h228, 32'h0001_0000, 1'b1);

        // R6 clear and event in the same cycle: event wins
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 12'h220; reg_wdata = 32'h0001_0000; cpl_pulse = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0; cpl_pulse = 1'b0;
        rd(12'h220, 32'h0001_0000, "R6 set wins over clear");

        // R6 clear works
        clear_done();
        rd(12'h220, 32'h0, "R6 write-one clears flag");
        check(irq == 1'b0, "R6 irq low after clear", irq, 0);

        // R2 count limit 3: fourth back-to-back completion fires
        wr(12'h20C, 32'h0000_837F, 1'b0);
        burst(4, 4);
        rd(12'h220, 32'h0001_0000, "R2 flag after count limit");

        // R4 completions during set flag still count toward next event
        burst(2, 0);
        clear_done();
        rd(12'h220, 32'h0, "R4 no early event after clear");
        burst(2, 2);
        rd(12'h220, 32'h0001_0000, "R4 event after 4 completions across clear");
        clear_done();

        // R2 count limit 0: first completion fires
        wr(12'h20C, 32'h0000_807F, 1'b0);
        burst(1, 1);
        clear_done();

        // R3 age limit 2, later completion does not restart the age
        wr(12'h20C, 32'h0000_FF02, 1'b0);
        burst(1, 3 * UNIT + 2);
        repeat (4) @(negedge clk);
        burst(1, 0);
        repeat (12) @(negedge clk);
        check(irq == 1'b1, "R3 irq after age limit", irq, 1);
        clear_done();

        // R4/R9 after the event the age is cleared: no further event
        repeat (50) @(negedge clk);
        rd(12'h220, 32'h0, "R9 no event after age reset");

        // R3 age limit 0
        wr(12'h20C, 32'h0000_FF00, 1'b0);
        burst(1, UNIT + 2);
        repeat (UNIT + 4) @(negedge clk);
        rd(12'h220, 32'h0001_0000, "R3 age limit zero");
        clear_done();

        // R8 readback masking and unmapped read
        wr(12'h20C, 32'hFFFF_FFFF, 1'b0);
        rd(12'h20C, 32'h0000_FF7F, "R8 field readback");
        rd(12'h100, 32'h0, "R8 unmapped read");

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R2/R3/R5 all expected rises seen", exp_q.size(), 0);
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    always @(posedge clk) begin
        if (!finished && cyc >= WATCHDOG) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule